// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, a segment number paired with an offset, into a physical address. The descriptor for each segment lives in an ordinary memory table. The unit reads the descriptor through a simple read port, then checks it and returns either the physical address or a fault code. Two context registers shape each translation. The table origin register gives the byte address of the table. The table length register gives the count of legal segment numbers. Software loads both registers at a context switch, while no translation is running.

A processor-side request is accepted with a valid/ready handshake, and only one translation is in flight at a time. A segment number that falls outside the table is rejected at once, and no descriptor is read for it. For a legal number the unit issues a single descriptor read, then checks the valid bit, the limit and the access permission. The response, carrying the address or the fault, is held until the requester takes it.

Top module: `seg_xlate_top`

## Requirements
- R1: While reset is applied and in the cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0. Both context registers reset to 0.
- R2: Once a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `req_ready` stays 0 until the response has been taken.
- R3: For a legal segment number the unit raises `mem_rd_en` for exactly one cycle, with `mem_rd_addr` = table origin + segment × 8. It then waits for `mem_rd_valid`. The data word is decoded as base in bits [31:0], limit in [47:32], valid in bit 48, read permission in 49, write in 50 and execute in 51.
- R4: A segment number greater than or equal to the table length gets fault code 1, and no descriptor read is issued.
- R5: A descriptor whose valid bit is 0 gets fault code 2.
- R6: An offset greater than or equal to the descriptor limit gets fault code 3.
- R7: Access code 0 (read) needs bit 49, code 1 (write) needs bit 50 and code 2 (execute) needs bit 51. Code 3 always fails. A failed permission check gets fault code 4.
- R8: When several faults apply, the lowest-numbered code is reported, in the order range, invalid, limit, permission.
- R9: With no fault, `rsp_fault` is 0 and `rsp_paddr` = base + offset, modulo 2^32. With a fault, `rsp_paddr` is 0.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its fields stay unchanged.
- R11: A write with `cfg_we` loads the table origin when `cfg_sel` is 0 and the table length when `cfg_sel` is 1. The write takes effect only in a cycle where `req_ready` is 1. At any other time it is ignored.
- R12: If a context write and a request acceptance happen in the same cycle, that request is translated with the old register values. Later requests see the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Context register write strobe |
| cfg_sel | input | 1 | 0 selects table origin, 1 selects table length |
| cfg_wdata | input | 32 | Context register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | 16 | Offset within segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 3 | Fault code, 0 when none |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_valid | input | 1 | Descriptor data returned |
| mem_rd_data | input | 52 | Used bits of the 8-byte descriptor |

## Verification
Two events can fall in one cycle: a context register write and the acceptance of a request. The bench provokes this by driving `cfg_we`, which shrinks the table length, in the same cycle as `req_valid` for a segment that only the old length allows. The result is judged from the responses alone. That request must translate cleanly, and an identical request right after it must get the range fault. A second case writes during a translation, while the descriptor read is pending. That write must leave no trace, which the bench confirms by the success of a later request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int PA_W       = 32;
    localparam int LIM_W      = 16;
    localparam int DESC_W     = PA_W + LIM_W + 4;
    localparam int DESC_BYTES = 8;
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PERM    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Field order gives bit positions: base lowest, then limit, valid, r, w, x
    typedef struct packed {
        logic              x_ok;
        logic              w_ok;
        logic              r_ok;
        logic              present;
        logic [LIM_W-1:0]  limit;
        logic [PA_W-1:0]   base;
    } seg_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

    function automatic logic perm_granted(seg_desc_t d, acc_e a);
        case (a)
            ACC_READ:  return d.r_ok;
            ACC_WRITE: return d.w_ok;
            ACC_EXEC:  return d.x_ok;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_ctx_regs.sv
module seg_ctx_regs
    import seg_xlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [PA_W-1:0] wr_data,
    input  logic            idle,
    output logic [PA_W-1:0] tbl_origin,
    output logic [PA_W-1:0] tbl_count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_origin <= '0;
            tbl_count  <= '0;
        end else if (wr_en && idle) begin
            if (wr_sel) tbl_count  <= wr_data;
            else        tbl_origin <= wr_data;
        end
    end

endmodule

// File: rtl/seg_fault_eval.sv
module seg_fault_eval
    import seg_xlate_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [LIM_W-1:0]  off,
    input  acc_e              acc,
    output fault_e            fault,
    output logic [PA_W-1:0]   paddr
);

    logic perm_ok;

    always_comb begin
        perm_ok = perm_granted(desc, acc);
        fault   = FLT_NONE;
        paddr   = '0;
        if (!desc.present)
            fault = FLT_INVALID;
        else if (off >= desc.limit)
            fault = FLT_LIMIT;
        else if (!perm_ok)
            fault = FLT_PERM;
        else
            paddr = desc.base + PA_W'(off);
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [PA_W-1:0]    cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [LIM_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [2:0]         rsp_fault,
    output logic               mem_rd_en,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [DESC_W-1:0]  mem_rd_data
);

    xl_state_e         st;
    logic [LIM_W-1:0]  cur_off;
    acc_e              cur_acc;
    logic [PA_W-1:0]   cur_daddr;
    fault_e            res_fault;
    logic [PA_W-1:0]   res_paddr;

    logic [PA_W-1:0]   tbl_origin;
    logic [PA_W-1:0]   tbl_count;
    fault_e            ev_fault;
    logic [PA_W-1:0]   ev_paddr;
    logic              seg_in_range;

    assign req_ready    = (st == ST_IDLE);
    assign rsp_valid    = (st == ST_RESP);
    assign mem_rd_en    = (st == ST_FETCH);
    assign mem_rd_addr  = cur_daddr;
    assign rsp_paddr    = res_paddr;
    assign rsp_fault    = res_fault;
    assign seg_in_range = PA_W'(req_seg) < tbl_count;

    seg_ctx_regs u_ctx (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata),
        .idle       (req_ready),
        .tbl_origin (tbl_origin),
        .tbl_count  (tbl_count)
    );

    seg_fault_eval u_eval (
        .desc  (seg_desc_t'(mem_rd_data)),
        .off   (cur_off),
        .acc   (cur_acc),
        .fault (ev_fault),
        .paddr (ev_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur_off   <= '0;
            cur_acc   <= ACC_READ;
            cur_daddr <= '0;
            res_fault <= FLT_NONE;
            res_paddr <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    cur_off <= req_off;
                    cur_acc <= acc_e'(req_acc);
                    if (seg_in_range) begin
                        cur_daddr <= tbl_origin + (PA_W'(req_seg) << DESC_SHIFT);
                        st        <= ST_FETCH;
                    end else begin
                        res_fault <= FLT_RANGE;
                        res_paddr <= '0;
                        st        <= ST_RESP;
                    end
                end
                ST_FETCH: st <= ST_WAIT;
                ST_WAIT: if (mem_rd_valid) begin
                    res_fault <= ev_fault;
                    res_paddr <= ev_paddr;
                    st        <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_fault,
    input logic        mem_rd_en
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_rd_en));

    // R2
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    resp_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R3
    single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == 32'd0));

    // R10
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

endmodule

bind seg_xlate_top seg_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .mem_rd_en (mem_rd_en)
);

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_fault;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [51:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    logic [31:0] last_rd_addr = '0;

    always #5 clk = ~clk;

    seg_xlate_top #(.SEG_W(4)) i_seg_xlate_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // Descriptor memory, indexed by byte address bits [8:3], two-cycle latency
    logic [51:0] dmem [64];
    logic        d1_v = 1'b0;
    logic [31:0] d1_a = '0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            rd_count     = rd_count + 1;
            last_rd_addr = mem_rd_addr;
        end
        d1_v         <= mem_rd_en;
        d1_a         <= mem_rd_addr;
        mem_rd_valid <= d1_v;
        mem_rd_data  <= dmem[d1_a[8:3]];
    end

    function automatic logic [51:0] mk(logic [31:0] b, logic [15:0] l,
                                       logic v, logic r, logic w, logic x);
        return {x, w, r, v, l, b};
    endfunction

    typedef struct packed {
        logic [3:0]  seg;
        logic [15:0] off;
        logic [1:0]  acc;
        logic [2:0]  flt;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0010, 2'd0, 3'd0, 32'h1000_0010},  // R9 read ok
        '{4'd0,  16'h00FF, 2'd2, 3'd0, 32'h1000_00FF},  // R6 last legal offset
        '{4'd0,  16'h0100, 2'd0, 3'd3, 32'h0},          // R6 offset == limit
        '{4'd0,  16'h0005, 2'd1, 3'd4, 32'h0},          // R7 no write
        '{4'd1,  16'h003F, 2'd1, 3'd0, 32'h2000_003F},  // R7 write ok
        '{4'd1,  16'h0001, 2'd2, 3'd4, 32'h0},          // R7 no exec
        '{4'd2,  16'h0000, 2'd0, 3'd2, 32'h0},          // R5 invalid
        '{4'd2,  16'hFFFF, 2'd3, 3'd2, 32'h0},          // R8 invalid over limit/perm
        '{4'd4,  16'h0000, 2'd0, 3'd1, 32'h0},          // R4 seg == length
        '{4'd1,  16'h0050, 2'd2, 3'd3, 32'h0},          // R8 limit over perm
        '{4'd3,  16'h01FF, 2'd0, 3'd0, 32'h0000_00FF},  // R9 wraparound
        '{4'd1,  16'h0000, 2'd3, 3'd4, 32'h0},          // R7 reserved access
        '{4'd15, 16'h0000, 2'd1, 3'd1, 32'h0}           // R4 top segment number
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xact(logic [3:0] s, logic [15:0] o, logic [1:0] a,
                        output logic [2:0] f, output logic [31:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        f = rsp_fault;
        p = rsp_paddr;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0]  f;
        logic [31:0] p;
        int          rc0;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        dmem[32] = mk(32'h1000_0000, 16'h0100, 1'b1, 1'b1, 1'b0, 1'b1);
        dmem[33] = mk(32'h2000_0000, 16'h0040, 1'b1, 1'b1, 1'b1, 1'b0);
        dmem[34] = mk(32'h0000_3000, 16'h0010, 1'b0, 1'b1, 1'b1, 1'b1);
        dmem[35] = mk(32'hFFFF_FF00, 16'h0200, 1'b1, 1'b1, 1'b1, 1'b1);
        dmem[0]  = mk(32'h5000_0000, 16'h0010, 1'b1, 1'b1, 1'b1, 1'b1);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 mem_rd_en", mem_rd_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {req_ready, rsp_valid, mem_rd_en}, 3'b100);

        // R1 length resets to 0: every segment is out of range
        xact(4'd0, 16'h0, 2'd0, f, p);
        chk("R1 R4 zero length fault", f, 3'd1);

        cfg_write(1'b0, 32'h0000_0100);  // R11 origin
        cfg_write(1'b1, 32'd4);          // R11 length

        for (int i = 0; i < NV; i++) begin
            rc0 = rd_count;
            xact(VECS[i].seg, VECS[i].off, VECS[i].acc, f, p);
            chk($sformatf("R8 vec%0d fault", i), f, VECS[i].flt);
            chk($sformatf("R9 vec%0d paddr", i), p, VECS[i].pa);
            if (VECS[i].flt == 3'd1) begin
                chk($sformatf("R4 vec%0d no read", i), rd_count - rc0, 0);
            end else begin
                chk($sformatf("R3 vec%0d one read", i), rd_count - rc0, 1);
                chk($sformatf("R3 vec%0d read addr", i), last_rd_addr,
                    32'h100 + 32'(VECS[i].seg) * 8);
            end
        end

        // R2 and R10: backpressure on the response
        @(negedge clk);
        req_valid = 1'b1; req_seg = 4'd1; req_off = 16'h0004; req_acc = 2'd0;
        rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after accept", req_ready, 0);
        while (!rsp_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 held valid", rsp_valid, 1);
        chk("R10 held paddr", rsp_paddr, 32'h2000_0004);
        chk("R2 still busy", req_ready, 0);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R10 released", {rsp_valid, req_ready}, 2'b01);

        // R11: a write while a translation is pending is ignored
        @(negedge clk);
        req_valid = 1'b1; req_seg = 4'd0; req_off = 16'h0001; req_acc = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
        xact(4'd3, 16'h0000, 2'd0, f, p);
        chk("R11 busy write ignored", {f, p}, {3'd0, 32'hFFFF_FF00});

        // R12: write and acceptance in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_seg = 4'd3; req_off = 16'h0010; req_acc = 2'd1;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'd1;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk("R12 old length used", {rsp_fault, rsp_paddr}, {3'd0, 32'hFFFF_FF10});
        xact(4'd3, 16'h0010, 2'd1, f, p);
        chk("R12 new length applies", f, 3'd1);
        xact(4'd0, 16'h0002, 2'd0, f, p);
        chk("R12 seg0 still legal", {f, p}, {3'd0, 32'h1000_0002});

        // R11 origin change moves the descriptor fetch
        cfg_write(1'b0, 32'h0000_0200);
        xact(4'd0, 16'h0004, 2'd1, f, p);
        chk("R11 R3 new origin addr", last_rd_addr, 32'h0000_0200);
        chk("R11 new origin result", {f, p}, {3'd0, 32'h5000_0004});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule